// File: doc/BRIEF.md
# Frame Word Pixel Unpacker

This block sits between a frame-buffer fetch path and a display pipeline. It accepts 32-bit words from memory on a valid/ready stream and hands out one pixel per cycle on a second valid/ready stream. A three-bit depth code selects the pixel width. Indexed depths of 1, 2, 4 and 8 bits yield a palette index. Direct depths of 16 and 32 bits and a 12-bit 4-4-4 format yield 24-bit RGB.

Two ordering controls pick where each pixel sits inside a word. A colour-order bit picks which end of the pixel holds red. For the generic 16-bit code, an external two-bit selector picks the layout on variants that have no native 5-6-5 depth code. A line-length input sets the number of pixels per line. At the end of a line the rest of the current word is dropped, so every line starts on a fresh word.

Back-pressure works as follows. Input: a word transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever no word is held, and also in the cycle where the last pixel to be used from the held word is taken. Output: while `out_valid` is high and `out_ready` is low, every pixel output stays stable. The configuration inputs may change only while the block is in reset.

Top module: `pxu_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken only on `in_valid && in_ready`, and a pixel only on `out_valid && out_ready`. A stalled pixel holds its outputs. `in_ready` is high exactly when no word is held, or when the pixel being taken is the last one used from the held word.
- R3: Depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel as an index. For these codes `out_direct` is 0, `out_index` is the zero-extended field and `out_rgb` is 0. Codes 4, 5, 6 and 7 set `out_direct` to 1 with `out_index` at 0. A word gives 32/bpp pixels, where codes 4, 6 and 7 occupy 16 bits.
- R4: With both ordering bits low, pixel k of a word is taken from bits [k*bpp +: bpp], least significant first.
- R5: With `be_pixels` high and `be_bytes` low, bytes are used from least significant upward. For depths below 8, pixels within a byte run from its most significant end. For depths of 8 and above the bit has no effect.
- R6: With `be_bytes` high, pixel k comes from bits [32-(k+1)*bpp +: bpp], whatever `be_pixels` is.
- R7: Code 5 reads three 8-bit channels as c0 = bits 7:0, c1 = bits 15:8 and c2 = bits 23:16. Bits 31:24 are ignored.
- R8: When `native_565` is 1, code 4 is always 5-5-5-1, with c0 = 4:0, c1 = 9:5 and c2 = 14:10, and `fmt_mux` is ignored.
- R9: When `native_565` is 0, code 4 is read as 5-5-5-1 for `fmt_mux` = 1. For `fmt_mux` = 3 it is 5-6-5 with `swap_bgr` treated as 1. For `fmt_mux` = 0 or 2 it is 5-6-5 with `swap_bgr` honoured. 5-6-5 uses c0 = 4:0, c1 = 10:5 and c2 = 15:11.
- R10: Code 6 is 5-6-5. Code 7 is 4-4-4 with c0 = 3:0, c1 = 7:4 and c2 = 11:8.
- R11: `out_rgb` is {red, green, blue} in bits 23:16, 15:8 and 7:0. Green is c1. With `swap_bgr` = 1, red is c0 and blue is c2. With 0 they trade places.
- R12: `out_eol` is high with pixel number `line_px` of each line. The unused pixels of that word are discarded, and the next pixel comes from the next word.
- R13: Channels narrower than 8 bits are shifted to the top of the byte with zero fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_code | input | 3 | Pixel depth select |
| swap_bgr | input | 1 | Colour order: 1 puts red in the low field |
| be_bytes | input | 1 | Whole word read from its most significant end |
| be_pixels | input | 1 | Sub-byte pixels read from the top of each byte |
| fmt_mux | input | 2 | External 16-bit layout selector |
| native_565 | input | 1 | Variant has its own 5-6-5 code |
| line_px | input | COL_W | Pixels per line (1 or more) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| in_data | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel offered |
| out_ready | input | 1 | Pixel consumer ready |
| out_direct | output | 1 | Pixel is RGB rather than an index |
| out_index | output | 8 | Palette index |
| out_rgb | output | 24 | Direct colour |
| out_eol | output | 1 | Last pixel of a line |

## Verification
Two events can land in the same cycle. The first is the end of a line on the last pixel of a word, which releases the held word while a new one is accepted. The second is the end of a line in mid-word, which drops the word's tail at once. The bench sets line lengths that make each happen, using random input gaps and random output stalls. Each cycle it compares `out_valid` and `in_ready` against the occupancy of its own expected-pixel queue. Every transferred pixel, `out_eol` included, must match the front of that queue.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
  localparam int WORD_W = 32;
  localparam int LG_MAX = $clog2(WORD_W);
  localparam int IDX_W  = 8;
  localparam int CH_W   = 8;
  localparam int RAW_W  = 3 * CH_W;

  typedef enum logic [2:0] {
    DC_1 = 3'd0, DC_2 = 3'd1, DC_4 = 3'd2, DC_8 = 3'd3,
    DC_16 = 3'd4, DC_32 = 3'd5, DC_565 = 3'd6, DC_444 = 3'd7
  } depth_e;

  typedef enum logic [2:0] {
    PF_INDEX, PF_888, PF_5551, PF_565, PF_444
  } pfmt_e;

  function automatic logic [2:0] depth_lg(depth_e d);
    case (d)
      DC_1:    return 3'd0;
      DC_2:    return 3'd1;
      DC_4:    return 3'd2;
      DC_8:    return 3'd3;
      DC_32:   return 3'd5;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pxu_word_hold.sv
`timescale 1ns/1ps
module pxu_word_hold
  import pxu_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        lg,
  input  logic [COL_W-1:0]  line_px,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_ready,
  output logic              held,
  output logic [WORD_W-1:0] word,
  output logic [LG_MAX-1:0] k,
  output logic              line_end
);
  localparam int K_W = LG_MAX;

  logic [COL_W-1:0] col_q;
  logic [K_W-1:0]   k_last;
  logic             word_end, take, release_w, accept;

  // index of the last pixel slot in a word at this depth
  assign k_last    = K_W'((WORD_W >> lg) - 1);
  assign line_end  = held && (col_q == COL_W'(line_px - 1'b1));
  assign word_end  = (k == k_last);
  assign take      = held && out_ready;
  assign release_w = take && (line_end || word_end);
  assign in_ready  = !held || release_w;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      word  <= '0;
      k     <= '0;
      col_q <= '0;
    end else begin
      if (accept) begin
        held <= 1'b1;
        word <= in_data;
        k    <= '0;
      end else if (release_w) begin
        held <= 1'b0;
        k    <= '0;
      end else if (take) begin
        k <= k + 1'b1;
      end
      if (take) col_q <= line_end ? '0 : col_q + 1'b1;
    end
  end
endmodule

// File: rtl/pxu_field_pick.sv
`timescale 1ns/1ps
module pxu_field_pick
  import pxu_pkg::*;
#(
  parameter int OUT_W = RAW_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LG_MAX-1:0] k,
  input  logic [2:0]        lg,
  input  logic              be_bytes,
  input  logic              be_pixels,
  output logic [OUT_W-1:0]  raw
);
  localparam int NL  = LG_MAX + 1;
  localparam int K_W = LG_MAX;
  localparam int BYTE_LG = 3;

  logic [OUT_W-1:0] cand [NL];

  for (genvar L = 0; L < NL; L++) begin : g_lg
    localparam int W = 1 << L;
    localparam int P = WORD_W >> L;
    logic [K_W-1:0]    off;
    logic [WORD_W-1:0] shifted;

    if (L < BYTE_LG) begin : g_sub
      localparam int PPB = 8 >> L;
      always_comb begin
        if (be_bytes)
          off = K_W'((P - 1 - int'(k)) << L);
        else if (be_pixels)
          off = K_W'(((int'(k) >> (BYTE_LG - L)) << 3) + (8 - W)
                     - ((int'(k) & (PPB - 1)) << L));
        else
          off = K_W'(int'(k) << L);
      end
    end else begin : g_whole
      always_comb begin
        if (be_bytes) off = K_W'((P - 1 - int'(k)) << L);
        else          off = K_W'(int'(k) << L);
      end
    end

    assign shifted = word >> off;
    assign cand[L] = OUT_W'(shifted & WORD_W'((64'd1 << W) - 1));
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < NL; i++)
      if (lg == 3'(i)) raw = cand[i];
  end
endmodule

// File: rtl/pxu_color_map.sv
`timescale 1ns/1ps
module pxu_color_map
  import pxu_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  depth_e           code,
  input  logic             swap_bgr,
  input  logic [1:0]       fmt_mux,
  input  logic             native_565,
  output logic             direct,
  output logic [IDX_W-1:0] index,
  output logic [3*CH_W-1:0] rgb
);
  pfmt_e fmt;
  logic  eff_bgr;
  logic [CH_W-1:0] c0, c1, c2;

  always_comb begin
    eff_bgr = swap_bgr;
    unique case (code)
      DC_1, DC_2, DC_4, DC_8: fmt = PF_INDEX;
      DC_32:  fmt = PF_888;
      DC_565: fmt = PF_565;
      DC_444: fmt = PF_444;
      default: begin
        if (native_565) fmt = PF_5551;
        else begin
          unique case (fmt_mux)
            2'd1: fmt = PF_5551;
            2'd3: begin fmt = PF_565; eff_bgr = 1'b1; end
            default: fmt = PF_565;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    c0 = '0; c1 = '0; c2 = '0;
    unique case (fmt)
      PF_888:  begin c0 = raw[7:0]; c1 = raw[15:8]; c2 = raw[23:16]; end
      PF_5551: begin
        c0 = {raw[4:0], 3'b0}; c1 = {raw[9:5], 3'b0}; c2 = {raw[14:10], 3'b0};
      end
      PF_565: begin
        c0 = {raw[4:0], 3'b0}; c1 = {raw[10:5], 2'b0}; c2 = {raw[15:11], 3'b0};
      end
      PF_444: begin
        c0 = {raw[3:0], 4'b0}; c1 = {raw[7:4], 4'b0}; c2 = {raw[11:8], 4'b0};
      end
      default: ;
    endcase
  end

  assign direct = (fmt != PF_INDEX);
  assign index  = direct ? '0 : raw[IDX_W-1:0];
  assign rgb    = !direct ? '0 : (eff_bgr ? {c0, c1, c2} : {c2, c1, c0});
endmodule

// File: rtl/pxu_top.sv
`timescale 1ns/1ps
module pxu_top
  import pxu_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        depth_code,
  input  logic              swap_bgr,
  input  logic              be_bytes,
  input  logic              be_pixels,
  input  logic [1:0]        fmt_mux,
  input  logic              native_565,
  input  logic [COL_W-1:0]  line_px,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_direct,
  output logic [7:0]        out_index,
  output logic [23:0]       out_rgb,
  output logic              out_eol
);
  depth_e            code;
  logic [2:0]        lg;
  logic              held, line_end;
  logic [WORD_W-1:0] word;
  logic [LG_MAX-1:0] k;
  logic [RAW_W-1:0]  raw;

  assign code = depth_e'(depth_code);
  assign lg   = depth_lg(code);

  pxu_word_hold #(.COL_W(COL_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .lg(lg), .line_px(line_px),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_ready(out_ready), .held(held), .word(word), .k(k),
    .line_end(line_end)
  );

  pxu_field_pick #(.OUT_W(RAW_W)) u_pick (
    .word(word), .k(k), .lg(lg), .be_bytes(be_bytes),
    .be_pixels(be_pixels), .raw(raw)
  );

  pxu_color_map u_map (
    .raw(raw), .code(code), .swap_bgr(swap_bgr), .fmt_mux(fmt_mux),
    .native_565(native_565), .direct(out_direct), .index(out_index),
    .rgb(out_rgb)
  );

  assign out_valid = held;
  assign out_eol   = line_end;
endmodule

// File: rtl/pxu_top_chk.sv
`timescale 1ns/1ps
module pxu_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  depth_code,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_direct,
  input logic [7:0]  out_index,
  input logic [23:0] out_rgb,
  input logic        out_eol
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready)) else $error("reset state"); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) &&
     $stable(out_index) && $stable(out_eol) && $stable(out_direct)))
    else $error("stalled pixel moved"); // R2

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready) else $error("not ready while empty"); // R2

  AST_INDEX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_direct ? (out_index == 8'h0) : (out_rgb == 24'h0)))
    else $error("index and rgb both set"); // R3

  AST_ONE_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && depth_code == 3'd0) |-> (out_index[7:1] == 7'h0))
    else $error("1 bpp index too wide"); // R3

  AST_EOL_FREES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eol) |-> in_ready)
    else $error("line end did not free word"); // R12

  AST_WIDEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && depth_code == 3'd7) |-> (out_rgb[3:0] == 4'h0 &&
     out_rgb[11:8] == 4'h0 && out_rgb[19:16] == 4'h0))
    else $error("widening not zero filled"); // R13
endmodule

bind pxu_top pxu_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .depth_code(depth_code), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_direct(out_direct),
  .out_index(out_index), .out_rgb(out_rgb), .out_eol(out_eol)
);

// File: tb/pxu_top_test.sv
`timescale 1ns/1ps
module pxu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  depth_code = 3'd0;
  logic        swap_bgr = 1'b0, be_bytes = 1'b0, be_pixels = 1'b0;
  logic [1:0]  fmt_mux = 2'd0;
  logic        native_565 = 1'b0;
  logic [11:0] line_px = 12'd1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_direct;
  logic [7:0]  out_index;
  logic [23:0] out_rgb;
  logic        out_eol;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int col = 0;
  logic [33:0] q[$];

  always #2.5 clk = ~clk;

  pxu_top #(.COL_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .depth_code(depth_code), .swap_bgr(swap_bgr),
    .be_bytes(be_bytes), .be_pixels(be_pixels), .fmt_mux(fmt_mux),
    .native_565(native_565), .line_px(line_px), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_direct(out_direct), .out_index(out_index),
    .out_rgb(out_rgb), .out_eol(out_eol)
  );

  task automatic check(string tag, string what, logic [33:0] act, logic [33:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model: expand one accepted word into expected pixels
  function automatic void expand(logic [31:0] w);
    int bpp, ppw, ppb, off, c0, c1, c2, idx;
    logic [31:0] v;
    bit dir, eb, last;
    logic [23:0] rgb;
    case (depth_code)
      3'd0: bpp = 1;  3'd1: bpp = 2;  3'd2: bpp = 4;
      3'd3: bpp = 8;  3'd5: bpp = 32; default: bpp = 16;
    endcase
    ppw = 32 / bpp;
    for (int k = 0; k < ppw; k++) begin
      if (be_bytes) off = 32 - bpp * (k + 1);
      else if (be_pixels && bpp < 8) begin
        ppb = 8 / bpp;
        off = (k / ppb) * 8 + 8 - bpp * ((k % ppb) + 1);
      end else off = k * bpp;
      v = (bpp == 32) ? w : ((w >> off) & ((32'd1 << bpp) - 1));
      eb = swap_bgr; dir = 1; idx = 0; c0 = 0; c1 = 0; c2 = 0;
      if (depth_code < 3'd4) begin
        dir = 0; idx = int'(v);
      end else if (depth_code == 3'd5) begin
        c0 = int'(v & 255); c1 = int'((v >> 8) & 255); c2 = int'((v >> 16) & 255);
      end else if (depth_code == 3'd7) begin
        c0 = int'(v & 15) * 16; c1 = int'((v >> 4) & 15) * 16; c2 = int'((v >> 8) & 15) * 16;
      end else if (depth_code == 3'd6 || (!native_565 && fmt_mux != 2'd1)) begin
        if (depth_code == 3'd4 && fmt_mux == 2'd3) eb = 1;
        c0 = int'(v & 31) * 8; c1 = int'((v >> 5) & 63) * 4; c2 = int'((v >> 11) & 31) * 8;
      end else begin
        c0 = int'(v & 31) * 8; c1 = int'((v >> 5) & 31) * 8; c2 = int'((v >> 10) & 31) * 8;
      end
      rgb = !dir ? 24'h0 : (eb ? {c0[7:0], c1[7:0], c2[7:0]} : {c2[7:0], c1[7:0], c0[7:0]});
      col++;
      last = (col == int'(line_px));
      q.push_back({last, dir, idx[7:0], rgb});
      if (last) begin col = 0; break; end
    end
  endfunction

  task automatic run(string tag, logic [2:0] dc, bit bgr, bit bb, bit pb,
                     logic [1:0] mx, bit nat, int cols, int nwords);
    int sent = 0, cyc = 0;
    bit took = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    depth_code = dc; swap_bgr = bgr; be_bytes = bb; be_pixels = pb;
    fmt_mux = mx; native_565 = nat; line_px = 12'(cols);
    q.delete(); col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", "reset valid/ready", {32'h0, out_valid, in_ready}, {32'h0, 2'b01});
    while ((sent < nwords || q.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (took) begin in_valid = 1'b0; took = 0; end
      if (!in_valid && sent < nwords && ($urandom % 4) != 0) begin
        in_valid = 1'b1; in_data = $urandom;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      check("R2", "out_valid", {33'h0, out_valid}, {33'h0, q.size() > 0});
      check("R2", "in_ready", {33'h0, in_ready},
            {33'h0, (q.size() == 0) || (out_ready && q.size() == 1)});
      if (out_valid && out_ready && q.size() > 0) begin
        check(tag, "pixel {eol,dir,idx,rgb}",
              {out_eol, out_direct, out_index, out_rgb}, q.pop_front());
      end
      if (in_valid && in_ready) begin
        expand(in_data); sent++; took = 1;
      end
    end
    if (cyc >= 20000) check(tag, "scenario timeout", 34'h1, 34'h0);
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    run("R3/R4/R12 1bpp lsb-first", 3'd0, 0, 0, 0, 2'd0, 0, 40, 24);
    run("R5/R12 2bpp pixel-msb, eol on word end", 3'd1, 0, 0, 1, 2'd0, 0, 16, 24);
    run("R6 4bpp byte-be over pixel-be", 3'd2, 0, 1, 1, 2'd0, 0, 12, 24);
    run("R5 8bpp pixel-be no effect", 3'd3, 0, 0, 1, 2'd0, 0, 6, 24);
    run("R7/R11 32bpp bgr clear", 3'd5, 0, 0, 0, 2'd0, 0, 5, 24);
    run("R7/R11 32bpp bgr set, byte-be", 3'd5, 1, 1, 0, 2'd0, 0, 7, 24);
    run("R8 code4 native, mux ignored", 3'd4, 1, 0, 0, 2'd3, 1, 3, 24);
    run("R9 code4 legacy mux1 5551", 3'd4, 0, 0, 0, 2'd1, 0, 4, 24);
    run("R9 code4 legacy mux3 forced bgr", 3'd4, 0, 0, 0, 2'd3, 0, 5, 24);
    run("R9 code4 legacy mux2 honours bgr", 3'd4, 0, 0, 0, 2'd2, 0, 5, 24);
    run("R9 code4 legacy mux0 bgr set", 3'd4, 1, 1, 0, 2'd0, 0, 3, 24);
    run("R10 code6 565 byte-be", 3'd6, 1, 1, 0, 2'd0, 0, 9, 24);
    run("R10/R13 code7 444", 3'd7, 0, 0, 0, 2'd0, 0, 1, 24);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule